// File: doc/BRIEF.md
# Packed 64-bit Integer Media ALU

This unit performs packed integer media arithmetic on two 64-bit operands. It views them either as eight unsigned byte lanes or as four 16-bit word lanes. A 4-bit opcode selects one operation per cycle:

- lane-wise rounded averages, minimum/maximum and unsigned high-half multiply;
- a byte-wise sum of absolute differences reduced to one count;
- gathering the sign bit of every byte into a mask;
- immediate-controlled word shuffle, word extract and word insert.

An 8-bit immediate supplies the shuffle selectors and the word lane number. Results appear one clock after an accepted request, on a 64-bit vector output and a 32-bit scalar output. The scalar output carries the result of the extract and mask operations.

The operation logic is purely combinational. One register stage captures the selected result when the request strobe is high. The outputs keep their value while no request arrives. A datapath places the unit after operand fetch and reads the outputs one cycle after issue.

Top module: `pmx_alu64`

## Requirements
- R1: Opcode 0 averages each of the eight unsigned byte lanes as (a+b+1)>>1, and opcode 1 does the same for the four unsigned word lanes. No lane sum overflows. Example: bytes FF and 00 give 80.
- R2: Opcode 2 sums the absolute differences of the eight unsigned byte pairs. The sum goes in vector bits 15:0, and bits 63:16 and the scalar are zero. Eight pairs of FF and 00 give 0x07F8.
- R3: Opcodes 3 (maximum) and 4 (minimum) compare each word lane as a signed 16-bit value.
- R4: Opcodes 5 (maximum) and 6 (minimum) compare each byte lane as an unsigned 8-bit value.
- R5: Opcode 7 multiplies each pair of unsigned word lanes and returns the upper 16 bits of each 32-bit product in that lane.
- R6: Opcode 8 sets scalar bit i to the top bit of byte lane i of operand A. Scalar bits 31:8 and the whole vector output are zero.
- R7: Opcode 9 fills destination word i with word number imm[2i+1:2i] of operand A. Word 0 is bits 15:0.
- R8: Opcode 10 places word number imm[1:0] of operand A on the scalar output, zero-extended. The vector output is zero, and imm[7:2] has no effect.
- R9: Opcode 11 returns operand A with word number imm[1:0] replaced by B bits 15:0. The scalar is zero, and imm[7:2] has no effect.
- R10: out_valid is in_valid delayed by one clock. A request's results appear on the clock edge that accepts it.
- R11: While in_valid is low, the vector and scalar outputs keep their previous values whatever the other inputs do.
- R12: During and directly after reset, out_valid, the vector output and the scalar output are zero.
- R13: Opcodes 12 to 15 produce zero on both the vector and the scalar output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; inputs are taken this cycle |
| op | input | 4 | Operation code |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| imm | input | 8 | Shuffle selectors / word lane number |
| out_valid | output | 1 | Results below belong to the previous request |
| res | output | 64 | Vector result |
| scalar | output | 32 | Scalar result for mask and extract |

## Verification
The vectors target the spots where signedness and rounding are easy to get wrong:

- **Signed word compare.** 0x8000 is paired against 0x0001 and 0x7FFF, so a word compare done unsigned picks the wrong lane.
- **Average overflow.** FF+FF+1 is averaged, so an average without a carry bit wraps to a small value.
- **Average rounding.** Odd sums are used, so truncating instead of rounding up shows in the low bit.
- **SAD range.** The SAD runs at its maximum of 0x7F8, so an accumulator too narrow drops the top bit.
- **Multiply half.** FFFF*FFFF is used, so keeping the low product half instead of the high half shows at once.
- **Shuffle selectors.** A reversing shuffle and a broadcast shuffle expose swapped selector fields.
- **Lane number.** Extract and insert are run with the upper immediate bits set, so decoding more than two bits picks the wrong lane.
- **Hold.** A run with the strobe low while inputs change shows whether the registers load without a request.

// File: rtl/pmx_pkg.sv
`timescale 1ns/1ps
package pmx_pkg;

    typedef enum logic [3:0] {
        OP_AVGB  = 4'd0,
        OP_AVGW  = 4'd1,
        OP_SAD   = 4'd2,
        OP_MAXSW = 4'd3,
        OP_MINSW = 4'd4,
        OP_MAXUB = 4'd5,
        OP_MINUB = 4'd6,
        OP_MULHU = 4'd7,
        OP_MSKB  = 4'd8,
        OP_SHUFW = 4'd9,
        OP_EXTRW = 4'd10,
        OP_INSRW = 4'd11
    } pmx_op_e;

    typedef struct packed {
        logic        valid;
        logic [63:0] res;
        logic [31:0] scal;
    } pmx_out_t;

endpackage

// File: rtl/pmx_lane_unit.sv
`timescale 1ns/1ps
module pmx_lane_unit #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] avgb,
    output logic [DATA_W-1:0] avgw,
    output logic [DATA_W-1:0] maxsw,
    output logic [DATA_W-1:0] minsw,
    output logic [DATA_W-1:0] maxub,
    output logic [DATA_W-1:0] minub,
    output logic [DATA_W-1:0] mulhu
);
    localparam int BYTES = DATA_W / 8;
    localparam int WORDS = DATA_W / 16;

    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        logic [7:0] ab, bb;
        logic [8:0] sum9;
        assign ab   = a[8*i +: 8];
        assign bb   = b[8*i +: 8];
        assign sum9 = {1'b0, ab} + {1'b0, bb} + 9'd1;
        assign avgb[8*i +: 8]  = sum9[8:1];
        assign maxub[8*i +: 8] = (ab > bb) ? ab : bb;
        assign minub[8*i +: 8] = (ab < bb) ? ab : bb;
    end

    for (genvar j = 0; j < WORDS; j++) begin : g_word
        logic [15:0] aw, bw;
        logic [16:0] sum17;
        assign aw    = a[16*j +: 16];
        assign bw    = b[16*j +: 16];
        assign sum17 = {1'b0, aw} + {1'b0, bw} + 17'd1;
        assign avgw[16*j +: 16]  = sum17[16:1];
        assign maxsw[16*j +: 16] = ($signed(aw) > $signed(bw)) ? aw : bw;
        assign minsw[16*j +: 16] = ($signed(aw) < $signed(bw)) ? aw : bw;
        assign mulhu[16*j +: 16] = 16'(({16'd0, aw} * {16'd0, bw}) >> 16);
    end
endmodule

// File: rtl/pmx_reduce_unit.sv
`timescale 1ns/1ps
module pmx_reduce_unit #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sad,
    output logic [31:0]       mask
);
    localparam int BYTES = DATA_W / 8;
    localparam int SUM_W = $clog2(BYTES * 255 + 1);

    logic [SUM_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = 0; i < BYTES; i++) begin
            if (a[8*i +: 8] > b[8*i +: 8])
                acc = acc + SUM_W'(a[8*i +: 8] - b[8*i +: 8]);
            else
                acc = acc + SUM_W'(b[8*i +: 8] - a[8*i +: 8]);
        end
    end

    assign sad = DATA_W'(acc);

    always_comb begin
        mask = '0;
        for (int i = 0; i < BYTES; i++)
            mask[i] = a[8*i + 7];
    end
endmodule

// File: rtl/pmx_permute_unit.sv
`timescale 1ns/1ps
module pmx_permute_unit #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [15:0]       ins_word,
    input  logic [7:0]        imm,
    output logic [DATA_W-1:0] shuf,
    output logic [DATA_W-1:0] ins,
    output logic [31:0]       ext
);
    localparam int WORDS = DATA_W / 16;
    localparam int SEL_W = $clog2(WORDS);

    logic [SEL_W-1:0] lane;
    assign lane = imm[SEL_W-1:0];

    for (genvar i = 0; i < WORDS; i++) begin : g_dst
        logic [SEL_W-1:0] pick;
        assign pick = imm[SEL_W*i +: SEL_W];
        assign shuf[16*i +: 16] = a[16*pick +: 16];
        assign ins[16*i +: 16]  = (lane == SEL_W'(i)) ? ins_word : a[16*i +: 16];
    end

    assign ext = {16'd0, a[16*lane +: 16]};
endmodule

// File: rtl/pmx_alu64.sv
`timescale 1ns/1ps
module pmx_alu64
    import pmx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [7:0]        imm,
    output logic              out_valid,
    output logic [DATA_W-1:0] res,
    output logic [31:0]       scalar
);
    logic [DATA_W-1:0] avgb, avgw, maxsw, minsw, maxub, minub, mulhu;
    logic [DATA_W-1:0] sad, shuf, ins;
    logic [31:0]       mask, ext;

    pmx_lane_unit #(.DATA_W(DATA_W)) u_lane (
        .a(src_a), .b(src_b), .avgb(avgb), .avgw(avgw), .maxsw(maxsw),
        .minsw(minsw), .maxub(maxub), .minub(minub), .mulhu(mulhu)
    );

    pmx_reduce_unit #(.DATA_W(DATA_W)) u_reduce (
        .a(src_a), .b(src_b), .sad(sad), .mask(mask)
    );

    pmx_permute_unit #(.DATA_W(DATA_W)) u_perm (
        .a(src_a), .ins_word(src_b[15:0]), .imm(imm),
        .shuf(shuf), .ins(ins), .ext(ext)
    );

    pmx_out_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.valid = in_valid;
        if (in_valid) begin
            out_d.res  = '0;
            out_d.scal = '0;
            case (pmx_op_e'(op))
                OP_AVGB:  out_d.res  = avgb;
                OP_AVGW:  out_d.res  = avgw;
                OP_SAD:   out_d.res  = sad;
                OP_MAXSW: out_d.res  = maxsw;
                OP_MINSW: out_d.res  = minsw;
                OP_MAXUB: out_d.res  = maxub;
                OP_MINUB: out_d.res  = minub;
                OP_MULHU: out_d.res  = mulhu;
                OP_MSKB:  out_d.scal = mask;
                OP_SHUFW: out_d.res  = shuf;
                OP_EXTRW: out_d.scal = ext;
                OP_INSRW: out_d.res  = ins;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid = out_q.valid;
    assign res       = out_q.res;
    assign scalar    = out_q.scal;

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R10
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res) && $stable(scalar)));
    // R2
    sad_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_SAD) |=> (res[DATA_W-1:16] == '0 && scalar == '0));
    // R6
    mask_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_MSKB) |=> (scalar[31:8] == '0 && res == '0));
    // R8
    extract_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_EXTRW) |=> (scalar[31:16] == '0 && res == '0));
endmodule

// File: tb/pmx_alu64_test.sv
`timescale 1ns/1ps
module pmx_alu64_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [63:0] src_a = '0, src_b = '0;
    logic [7:0]  imm = '0;
    logic        out_valid;
    logic [63:0] res;
    logic [31:0] scalar;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pmx_alu64 uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src_a(src_a), .src_b(src_b), .imm(imm),
        .out_valid(out_valid), .res(res), .scalar(scalar)
    );

    // fields: op[235:232] a[231:168] b[167:104] imm[103:96] res[95:32] scalar[31:0]
    localparam int NV = 16;
    localparam logic [235:0] VEC [NV] = '{
        {4'd0,  64'hFFFF_0102_0304_0506, 64'hFF00_0304_0506_0708, 8'h00, 64'hFF80_0203_0405_0607, 32'h0},
        {4'd1,  64'hFFFF_0001_0000_1234, 64'hFFFF_0002_0001_1234, 8'h00, 64'hFFFF_0002_0001_1234, 32'h0},
        {4'd2,  64'h00FF_1020_0000_0000, 64'hFF00_2010_0000_0000, 8'h00, 64'h0000_0000_0000_021E, 32'h0},
        {4'd2,  64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 8'h00, 64'h0000_0000_0000_07F8, 32'h0},
        {4'd3,  64'h8000_7FFF_FFFF_0001, 64'h0001_8000_0000_FFFF, 8'h00, 64'h0001_7FFF_0000_0001, 32'h0},
        {4'd4,  64'h8000_7FFF_FFFF_0001, 64'h0001_8000_0000_FFFF, 8'h00, 64'h8000_8000_FFFF_FFFF, 32'h0},
        {4'd5,  64'h807F_00FF_0102_0304, 64'h7F80_FF00_0201_0403, 8'h00, 64'h8080_FFFF_0202_0404, 32'h0},
        {4'd6,  64'h807F_00FF_0102_0304, 64'h7F80_FF00_0201_0403, 8'h00, 64'h7F7F_0000_0101_0303, 32'h0},
        {4'd7,  64'hFFFF_8000_0002_1234, 64'hFFFF_0002_8000_0001, 8'h00, 64'hFFFE_0001_0001_0000, 32'h0},
        {4'd8,  64'h8000_FF7F_0180_00FF, 64'h0,                  8'h00, 64'h0,                  32'h0000_00A5},
        {4'd9,  64'h4444_3333_2222_1111, 64'h0,                  8'h1B, 64'h1111_2222_3333_4444, 32'h0},
        {4'd9,  64'h4444_3333_2222_1111, 64'h0,                  8'h00, 64'h1111_1111_1111_1111, 32'h0},
        {4'd10, 64'h4444_3333_2222_1111, 64'h0,                  8'hFE, 64'h0,                  32'h0000_3333},
        {4'd11, 64'h4444_3333_2222_1111, 64'hFFFF_FFFF_FFFF_ABCD, 8'hFD, 64'h4444_3333_ABCD_1111, 32'h0},
        {4'd13, 64'h4444_3333_2222_1111, 64'h1234_5678_9ABC_DEF0, 8'h55, 64'h0,                  32'h0},
        {4'd15, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 64'h0,                  32'h0}
    };
    localparam string TAG [NV] = '{"R1", "R1", "R2", "R2", "R3", "R3", "R4", "R4",
                                    "R5", "R6", "R7", "R7", "R8", "R9", "R13", "R13"};

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] held_res;
        repeat (3) @(negedge clk);
        // R12: outputs during reset
        chk("R12", "valid in reset", 64'(out_valid), 64'h0);
        chk("R12", "res in reset", res, 64'h0);
        chk("R12", "scalar in reset", 64'(scalar), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: first cycle after release
        chk("R12", "valid after reset", 64'(out_valid), 64'h0);
        chk("R12", "res after reset", res, 64'h0);

        for (int i = 0; i < NV; i++) begin
            op       = VEC[i][235:232];
            src_a    = VEC[i][231:168];
            src_b    = VEC[i][167:104];
            imm      = VEC[i][103:96];
            in_valid = 1'b1;
            @(negedge clk);
            chk(TAG[i], "res", res, VEC[i][95:32]);
            chk(TAG[i], "scalar", 64'(scalar), 64'(VEC[i][31:0]));
            chk("R10", "valid", 64'(out_valid), 64'h1);
        end

        // R11 / R10: load a known result, then drop the strobe and change inputs
        op = 4'd7; src_a = 64'hFFFF_8000_0002_1234; src_b = 64'hFFFF_0002_8000_0001;
        imm = 8'h00; in_valid = 1'b1;
        @(negedge clk);
        held_res = res;
        chk("R5", "res before idle", held_res, 64'hFFFE_0001_0001_0000);
        in_valid = 1'b0; op = 4'd10; src_a = 64'h1234_1234_1234_1234; imm = 8'h03;
        @(negedge clk);
        chk("R10", "valid idle", 64'(out_valid), 64'h0);
        chk("R11", "res idle", res, 64'hFFFE_0001_0001_0000);
        chk("R11", "scalar idle", 64'(scalar), 64'h0);
        op = 4'd8; src_a = 64'h8080_8080_8080_8080;
        @(negedge clk);
        chk("R11", "res idle 2", res, 64'hFFFE_0001_0001_0000);
        chk("R11", "scalar idle 2", 64'(scalar), 64'h0);

        // R8: extract lane 3, upper immediate bits clear
        in_valid = 1'b1; op = 4'd10; src_a = 64'h9876_0000_0000_0000; imm = 8'h03;
        @(negedge clk);
        chk("R8", "extract lane3", 64'(scalar), 64'h0000_9876);
        chk("R10", "valid pulse", 64'(out_valid), 64'h1);
        // R9: insert at lane 0 with upper immediate bits set
        op = 4'd11; src_a = 64'h4444_3333_2222_1111; src_b = 64'h0000_0000_0000_5555; imm = 8'hFC;
        @(negedge clk);
        chk("R9", "insert lane0", res, 64'h4444_3333_2222_5555);
        chk("R9", "insert scalar", 64'(scalar), 64'h0);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R10", "valid after pulse", 64'(out_valid), 64'h0);

        finish_run();
    end
endmodule